// File: doc/BRIEF.md
# Bunch-Crossing Phase and Gate Generator

The block produces the timing signals that one bunch-crossing period needs. It runs on a fast sampling clock at a fixed multiple of the bunch clock. With the default settings that multiple is 16, so each period has 16 phase slots of 6 ns. A free-running slot counter starts at slot 0 when reset is released. Four 4-bit settings control the outputs. A global phase value moves the regenerated bunch clock. Three offsets, each added to the global phase modulo 16, place the rising edge of the enable gate, its falling edge and a one-slot data strobe. Changing the global phase therefore moves every edge together.

Settings are taken only at the boundary into slot 0, so a pulse is never cut short partway through a period. In normal mode the enable gate is also qualified by an external gate request, and the fast-clear output follows an external clear input. In test mode the block ignores both external inputs. It then opens the gate window in every period and makes its own one-slot fast-clear pulse once every 256 periods.

Top module: `bxp_gate_gen`

## Requirements
- R1: While rst_ni is low, and until the first rising clock edge after it goes high, bclk_o, gate_o, strobe_o and fclr_o are all 0.
- R2: Cycle n counts rising edges since reset was released. Slot s = n mod 16 and period p = n div 16. bclk_o is high in the 8 slots starting at slot g and wrapping modulo 16, where g is the global phase setting in effect for that period.
- R3: gate_o rises at slot L = (g + lead_ofs) mod 16 and falls at slot T = (g + trail_ofs) mod 16. It is high for the slots from L up to but not including T, counted modulo 16, so a window that passes slot 15 wraps into slots 0 and onward of the same period.
- R4: If L equals T, gate_o stays low for the whole period.
- R5: strobe_o is high for exactly one slot, slot (g + strb_ofs) mod 16.
- R6: All six setting inputs (glb_dly_i, lead_ofs_i, trail_ofs_i, strb_ofs_i, test_mode_i, ext_gate_i) are sampled at the rising edge that enters slot 0. They apply to the whole following period. Changes at any other time have no effect. Period 0 uses all-zero settings.
- R7: In normal mode (sampled test_mode_i = 0), gate_o is the R3 window ANDed with the sampled ext_gate_i. fclr_o equals ext_clear_i delayed by one clock.
- R8: In test mode (sampled test_mode_i = 1), gate_o is the R3/R4 window in every period whatever ext_gate_i is, and ext_clear_i has no effect on fclr_o.
- R9: In test mode, fclr_o is high only at slot 0 of a period whose index p satisfies p mod 256 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock, 16 slots per bunch period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_dly_i | input | 4 | Global phase slot for the bunch clock and base of all edges |
| lead_ofs_i | input | 4 | Gate rising-edge offset from the global phase |
| trail_ofs_i | input | 4 | Gate falling-edge offset from the global phase |
| strb_ofs_i | input | 4 | Data strobe offset from the global phase |
| test_mode_i | input | 1 | 1 selects internally generated gate and clear |
| ext_gate_i | input | 1 | External gate request, used in normal mode |
| ext_clear_i | input | 1 | External fast-clear, passed through in normal mode |
| bclk_o | output | 1 | Phase-shifted bunch clock |
| gate_o | output | 1 | Enable gate |
| strobe_o | output | 1 | One-slot data strobe |
| fclr_o | output | 1 | Fast-clear pulse |

## Verification
The main sweep steps through every combination of global phase, lead offset and trail offset, one period each, and gives the strobe offset a different value each time. This covers every edge position, every wrap past slot 15 and every equal-edge case. It separates a correct modulo add from one that saturates or leaves out the global term. In each period the settings are scrambled mid-period, which shows whether they are latched only at the slot-0 boundary. Random clear patterns and ext_gate_i values are applied in normal mode and then repeated in test mode across a 256-period rollover. A pass-through fault, a missed ignore or a clear pulse in the wrong period each shows up as a mismatch.

// File: rtl/bxp_pkg.sv
package bxp_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } gate_src_e;

  localparam int unsigned NUM_EDGE  = 3;
  localparam int unsigned EDGE_LEAD = 0;
  localparam int unsigned EDGE_TRL  = 1;
  localparam int unsigned EDGE_STRB = 2;
endpackage

// File: rtl/bxp_slot_ctr.sv
module bxp_slot_ctr #(
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned PER_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_q_o,
  output logic [SLOT_W-1:0] slot_d_o,
  output logic [PER_W-1:0]  per_d_o,
  output logic              wrap_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [PER_W-1:0]  per_q;

  assign wrap_o   = &slot_q;
  assign slot_d_o = slot_q + 1'b1;
  assign per_d_o  = wrap_o ? per_q + 1'b1 : per_q;
  assign slot_q_o = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      per_q  <= '0;
    end else begin
      slot_q <= slot_d_o;
      per_q  <= per_d_o;
    end
  end
endmodule

// File: rtl/bxp_cfg_shadow.sv
module bxp_cfg_shadow #(
  parameter int unsigned CFG_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CFG_W-1:0] cfg_q_o,
  output logic [CFG_W-1:0] cfg_d_o
);
  logic [CFG_W-1:0] cfg_q;

  // load only on entry to slot 0
  assign cfg_d_o = wrap_i ? cfg_i : cfg_q;
  assign cfg_q_o = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d_o;
  end
endmodule

// File: rtl/bxp_phase_dec.sv
module bxp_phase_dec
  import bxp_pkg::*;
#(
  parameter int unsigned SLOT_W = 4
) (
  input  logic [SLOT_W-1:0]               slot_i,
  input  logic [SLOT_W-1:0]               glb_i,
  input  logic [NUM_EDGE-1:0][SLOT_W-1:0] ofs_i,
  output logic                            bclk_o,
  output logic                            win_o,
  output logic                            hit_o
);
  logic [NUM_EDGE-1:0][SLOT_W-1:0] pos;
  logic [NUM_EDGE-1:0][SLOT_W-1:0] rel;
  logic [SLOT_W-1:0]               rel_g;
  logic [SLOT_W-1:0]               span;

  // every edge is an offset on the one global phase, modulo the slot count
  for (genvar e = 0; e < NUM_EDGE; e++) begin : g_edge
    assign pos[e] = glb_i + ofs_i[e];
    assign rel[e] = slot_i - pos[e];
  end

  assign rel_g  = slot_i - glb_i;
  assign bclk_o = ~rel_g[SLOT_W-1];
  assign span   = pos[EDGE_TRL] - pos[EDGE_LEAD];
  assign win_o  = (span != '0) && (rel[EDGE_LEAD] < span);
  assign hit_o  = (rel[EDGE_STRB] == '0);
endmodule

// File: rtl/bxp_gate_gen.sv
module bxp_gate_gen
  import bxp_pkg::*;
#(
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned PER_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] glb_dly_i,
  input  logic [SLOT_W-1:0] lead_ofs_i,
  input  logic [SLOT_W-1:0] trail_ofs_i,
  input  logic [SLOT_W-1:0] strb_ofs_i,
  input  logic              test_mode_i,
  input  logic              ext_gate_i,
  input  logic              ext_clear_i,
  output logic              bclk_o,
  output logic              gate_o,
  output logic              strobe_o,
  output logic              fclr_o
);
  localparam int unsigned CFG_W = 4 * SLOT_W + 2;
  localparam int unsigned TM_B  = CFG_W - 1;
  localparam int unsigned EG_B  = CFG_W - 2;

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [PER_W-1:0]  per_d;
  logic              wrap;
  logic [CFG_W-1:0]  cfg_in, cfg_q, cfg_d;

  logic [SLOT_W-1:0]               cur_g, cur_lead, cur_trail, nxt_g;
  logic                            cur_tm;
  logic [NUM_EDGE-1:0][SLOT_W-1:0] nxt_ofs;
  logic                            bclk_d, win_d, hit_d, gate_d, fclr_d;
  gate_src_e                       src_d;

  assign cfg_in = {test_mode_i, ext_gate_i, strb_ofs_i, trail_ofs_i, lead_ofs_i, glb_dly_i};

  bxp_slot_ctr #(.SLOT_W(SLOT_W), .PER_W(PER_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_q_o(slot_q),
    .slot_d_o(slot_d),
    .per_d_o (per_d),
    .wrap_o  (wrap)
  );

  bxp_cfg_shadow #(.CFG_W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wrap_i (wrap),
    .cfg_i  (cfg_in),
    .cfg_q_o(cfg_q),
    .cfg_d_o(cfg_d)
  );

  // settings in effect now (checker view)
  assign cur_g     = cfg_q[SLOT_W-1:0];
  assign cur_lead  = cfg_q[2*SLOT_W-1:SLOT_W];
  assign cur_trail = cfg_q[3*SLOT_W-1:2*SLOT_W];
  assign cur_tm    = cfg_q[TM_B];

  // settings for the slot being entered
  assign nxt_g   = cfg_d[SLOT_W-1:0];
  for (genvar e = 0; e < NUM_EDGE; e++) begin : g_ofs
    assign nxt_ofs[e] = cfg_d[(e+2)*SLOT_W-1:(e+1)*SLOT_W];
  end

  bxp_phase_dec #(.SLOT_W(SLOT_W)) u_dec (
    .slot_i(slot_d),
    .glb_i (nxt_g),
    .ofs_i (nxt_ofs),
    .bclk_o(bclk_d),
    .win_o (win_d),
    .hit_o (hit_d)
  );

  assign src_d  = gate_src_e'(cfg_d[TM_B]);
  assign gate_d = win_d & ((src_d == SRC_INT) | cfg_d[EG_B]);
  assign fclr_d = (src_d == SRC_INT) ? ((slot_d == '0) && (per_d == '0)) : ext_clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_o   <= 1'b0;
      gate_o   <= 1'b0;
      strobe_o <= 1'b0;
      fclr_o   <= 1'b0;
    end else begin
      bclk_o   <= bclk_d;
      gate_o   <= gate_d;
      strobe_o <= hit_d;
      fclr_o   <= fclr_d;
    end
  end
endmodule

// File: rtl/bxp_gate_chk.sv
module bxp_gate_chk #(
  parameter int unsigned SLOT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SLOT_W-1:0] slot_i,
  input logic [SLOT_W-1:0] g_i,
  input logic [SLOT_W-1:0] lead_i,
  input logic [SLOT_W-1:0] trail_i,
  input logic              tm_i,
  input logic              bclk_i,
  input logic              gate_i,
  input logic              strobe_i,
  input logic              fclr_i
);
  logic              armed_q;
  logic [SLOT_W-1:0] lead_pos, trail_pos;

  assign lead_pos  = g_i + lead_i;
  assign trail_pos = g_i + trail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (&slot_i) armed_q <= 1'b1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !bclk_i && !gate_i && !strobe_i && !fclr_i);

  // R2
  bclk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $rose(bclk_i) && slot_i != '0 |-> slot_i == g_i);

  // R3
  gate_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $rose(gate_i) && slot_i != '0 |-> slot_i == lead_pos);

  // R4
  gate_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_pos == trail_pos |-> !gate_i);

  // R5
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !(&slot_i) |=> !strobe_i);

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i != '0 |-> $stable({g_i, lead_i, trail_i, tm_i}));

  // R9
  tclr_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fclr_i && tm_i |-> slot_i == '0);
endmodule

bind bxp_gate_gen bxp_gate_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .slot_i  (slot_q),
  .g_i     (cur_g),
  .lead_i  (cur_lead),
  .trail_i (cur_trail),
  .tm_i    (cur_tm),
  .bclk_i  (bclk_o),
  .gate_i  (gate_o),
  .strobe_i(strobe_o),
  .fclr_i  (fclr_o)
);

// File: tb/sim_bxp_gate_gen.sv
`timescale 1ns/1ps
module sim_bxp_gate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] glb = '0, lead = '0, trl = '0, strb = '0;
  logic       tm = 1'b0, eg = 1'b0, eclr = 1'b0;
  logic       bclk, gate, strobe, fclr;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  typedef struct {
    int    cyc;
    bit    bclk, gate, strb, fclr;
    string rg, rf;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  bxp_gate_gen u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .glb_dly_i(glb), .lead_ofs_i(lead), .trail_ofs_i(trl), .strb_ofs_i(strb),
    .test_mode_i(tm), .ext_gate_i(eg), .ext_clear_i(eclr),
    .bclk_o(bclk), .gate_o(gate), .strobe_o(strobe), .fclr_o(fclr)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit act, input bit exp, input string r);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b cycle=%0d", r, act, exp, cyc);
    end
  endtask

  // monitor: compare when the design reaches the tagged cycle
  always @(negedge clk) begin
    if (sb.size() != 0 && sb[0].cyc == cyc) begin
      item_t it;
      it = sb.pop_front();
      chk(bclk,   it.bclk, "R2 R6 bclk");
      chk(gate,   it.gate, it.rg);
      chk(strobe, it.strb, "R5 strobe");
      chk(fclr,   it.fclr, it.rf);
    end
  end

  // driver: entered one cycle before slot 0 of the period
  task automatic run_period(input int g, input int lo, input int to, input int so,
                            input bit xg, input bit xt);
    int   p = (cyc + 1) / 16;
    int   l = (g + lo) % 16;
    int   t = (g + to) % 16;
    int   s = (g + so) % 16;
    bit [15:0] pat = 16'($urandom);
    for (int k = 0; k < 16; k++) begin
      item_t it;
      bit    w = (l != t) && (((k - l + 16) % 16) < ((t - l + 16) % 16));
      it.cyc  = cyc + 1 + k;
      it.bclk = ((k - g + 16) % 16) < 8;
      it.gate = w && (xt || xg);
      it.strb = (k == s);
      it.fclr = xt ? (k == 0 && (p % 256) == 0) : pat[k];
      it.rg   = (l == t) ? "R4 gate" : (xt ? "R8 gate" : (xg ? "R3 gate" : "R7 gate"));
      it.rf   = xt ? "R8 R9 fclr" : "R7 fclr";
      sb.push_back(it);
    end
    glb = 4'(g); lead = 4'(lo); trl = 4'(to); strb = 4'(so); eg = xg; tm = xt;
    for (int k = 0; k < 16; k++) begin
      eclr = pat[k];
      @(posedge clk); #2;
      if (k == 6) begin
        // mid-period changes must be ignored (R6)
        glb = ~glb; lead = lead + 4'd5; trl = trl + 4'd3; strb = ~strb; eg = ~eg; tm = ~tm;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(bclk, 1'b0, "R1 bclk"); chk(gate, 1'b0, "R1 gate");
    chk(strobe, 1'b0, "R1 strobe"); chk(fclr, 1'b0, "R1 fclr");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 after release, before first edge
    chk(bclk, 1'b0, "R1 bclk"); chk(gate, 1'b0, "R1 gate");
    chk(strobe, 1'b0, "R1 strobe"); chk(fclr, 1'b0, "R1 fclr");
    do begin @(posedge clk); #2; end while (cyc % 16 != 15);
    // full sweep in normal mode
    for (int g = 0; g < 16; g++)
      for (int lo = 0; lo < 16; lo++)
        for (int to = 0; to < 16; to++)
          run_period(g, lo, to, (g * 3 + lo + to) % 16, ((lo ^ to) & 3) != 0, 1'b0);
    // test mode across a 256-period rollover
    for (int i = 0; i < 300; i++)
      run_period(i % 16, (i * 7) % 16, (i * 5 + 3) % 16, i % 16, i[0], 1'b1);
    // back to normal mode
    for (int i = 0; i < 8; i++)
      run_period(i, i + 2, i + 9, 15 - i, 1'b1, 1'b0);
    repeat (4) @(posedge clk);
    #3;
    if (sb.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL scoreboard actual=%0d expected=0 items left", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=done cycles", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule